// File: doc/BRIEF.md
# Status Byte Holder and Write Permission Arbiter

This block keeps the eight-bit status byte of a serial nonvolatile memory and decides, request by request, whether a write into the storage array or a rewrite of the status byte may start. The serial front end decodes each command and presents it as a one-cycle strobe. A memory write also carries its target address, and a status rewrite carries its new byte. The block answers in the same cycle with a grant or a refusal. A granted write marks the device busy. The self-timed write engine later reports completion, and on that report the block commits any pending status contents and drops the write-enable latch.

The persistent fields live in ordinary registers and are loaded from a parameter at reset; they are the lock enable, the two block-protect bits and the two watchdog-select bits. The volatile write-enable latch and the user flag always clear at reset. A new status byte is held in a pending register and becomes visible only when the write cycle ends. When the lock-enable bit is set and the external lock pin is low, the status byte is frozen. Depending on the block-protect code, a quarter, a half or all of the array refuses writes.

Top module: `sr_guard`

## Requirements
- R1: While reset is asserted, and after it is released, the status byte reads 0x00 with the default persistent value, the watchdog select reads 0, and both grants are low.
- R2: The status byte layout from bit 7 down to bit 0 is lock enable, user flag, 0, 0, block-protect high, block-protect low, write-enable latch, busy.
- R3: An array write is granted in the cycle of its request only when the write-enable latch is 1, the device is not busy, and the address is outside the protected range.
- R4: With an 11-bit address, the protected ranges by block-protect code are: 00 none, 01 0x600 to 0x7FF, 10 0x400 to 0x7FF, 11 0x000 to 0x7FF. The ranges are the top quarter, the top half and the whole of the address space.
- R5: The set-enable strobe sets the write-enable latch, and the clear strobe clears it. A refused write leaves the latch unchanged.
- R6: The flag-set strobe sets the user flag, and the clear strobe also clears it.
- R7: A status rewrite is refused when the write-enable latch is 0, or when lock enable is 1 and the lock pin is low. In every other case it is granted when the latch is 1 and the device is idle.
- R8: A grant sets busy in the next cycle. Busy stays set until the done input arrives, and then busy and the write-enable latch both clear in the next cycle. Requests made while busy are refused.
- R9: The persistent fields change only when a status write completes. At that point lock enable takes data bit 7, the watchdog select takes bits 5:4 and block protect takes bits 3:2. Data bits 6, 1 and 0 are ignored.
- R10: Pulling the lock pin low while a status write is in progress does not abort that write, but it refuses the status rewrites that follow.
- R11: A done indication while the device is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| op_wr_en_set | input | 1 | Strobe: set the write-enable latch |
| op_wr_en_clr | input | 1 | Strobe: clear the write-enable latch and the user flag |
| op_flag_set | input | 1 | Strobe: set the user flag |
| op_sr_write | input | 1 | Strobe: request a status rewrite |
| op_arr_write | input | 1 | Strobe: request an array write |
| wr_addr | input | ADDR_W | Target address of the array write |
| sr_wdata | input | 8 | New status byte for a rewrite |
| lock_pin_n | input | 1 | External lock pin, low means lock |
| wr_done | input | 1 | Write cycle complete |
| status_q | output | 8 | Status byte |
| wd_sel | output | 2 | Committed watchdog select |
| array_grant | output | 1 | Array write accepted |
| status_grant | output | 1 | Status rewrite accepted |

## Verification
The bench builds the block with ADDR_W = 11 and an all-zero persistent reset value. With these values the three protected ranges fall on the 0x3FF/0x400 and 0x5FF/0x600 boundaries, and the bench probes both sides of each. Because the reset value is zero, the lock state can only be reached through a committed rewrite, so locking, the pin-low-during-write case and unlocking are all driven through the ports.

// File: rtl/srg_pkg.sv
`timescale 1ns/1ps
package srg_pkg;

  typedef struct packed {
    logic       lock_en;
    logic [1:0] wdsel;
    logic [1:0] blk;
  } nv_t;

  localparam int SB_LOCK = 7;
  localparam int SB_FLAG = 6;
  localparam int SB_BLKH = 3;
  localparam int SB_BLKL = 2;
  localparam int SB_WEL  = 1;
  localparam int SB_BUSY = 0;

  function automatic logic [7:0] pack_status(input nv_t nv, input logic flag,
                                             input logic wel, input logic busy);
    logic [7:0] s;
    s          = 8'h00;
    s[SB_LOCK] = nv.lock_en;
    s[SB_FLAG] = flag;
    s[SB_BLKH] = nv.blk[1];
    s[SB_BLKL] = nv.blk[0];
    s[SB_WEL]  = wel;
    s[SB_BUSY] = busy;
    return s;
  endfunction

  function automatic nv_t unpack_wdata(input logic [7:0] d);
    nv_t n;
    n.lock_en = d[7];
    n.wdsel   = d[5:4];
    n.blk     = d[3:2];
    return n;
  endfunction

endpackage

// File: rtl/srg_range_chk.sv
`timescale 1ns/1ps
module srg_range_chk #(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        blk,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TOP = ADDR_W - 1;

  logic in_quarter;
  logic in_half;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign in_quarter = &addr[TOP -: 2];
      assign in_half    = addr[TOP];
    end else begin : g_narrow
      assign in_quarter = addr[TOP];
      assign in_half    = addr[TOP];
    end
  endgenerate

  always_comb begin
    unique case (blk)
      2'b00:   hit = 1'b0;
      2'b01:   hit = in_quarter;
      2'b10:   hit = in_half;
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/srg_grant.sv
`timescale 1ns/1ps
module srg_grant (
  input  logic req_arr,
  input  logic req_sr,
  input  logic wel,
  input  logic busy,
  input  logic lock_en,
  input  logic lock_pin_n,
  input  logic range_hit,
  output logic grant_arr,
  output logic grant_sr
);
  logic ready;
  logic frozen;

  always_comb begin
    ready     = wel & ~busy;
    frozen    = lock_en & ~lock_pin_n;
    grant_arr = req_arr & ready & ~range_hit;
    grant_sr  = req_sr & ready & ~frozen;
  end
endmodule

// File: rtl/srg_regs.sv
`timescale 1ns/1ps
module srg_regs
  import srg_pkg::*;
#(
  parameter nv_t NV_INIT = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wen_set,
  input  logic       wen_clr,
  input  logic       flag_set,
  input  logic       grant_arr,
  input  logic       grant_sr,
  input  logic [7:0] sr_wdata,
  input  logic       wr_done,
  output logic       wel,
  output logic       flag,
  output logic       busy,
  output nv_t        nv
);
  logic commit;
  logic wel_d, flag_d, busy_d, pend_sr_d;
  logic pend_sr;
  nv_t  pend, pend_d, nv_d;
  logic pend_en, nv_en;
  logic unused_bits;

  assign unused_bits = ^{sr_wdata[6], sr_wdata[1:0]};

  always_comb begin
    commit  = busy & wr_done;
    pend_en = grant_sr;
    nv_en   = commit & pend_sr;
    pend_d  = unpack_wdata(sr_wdata);
    nv_d    = pend;

    busy_d = busy;
    if (commit)                      busy_d = 1'b0;
    else if (grant_arr || grant_sr)  busy_d = 1'b1;

    wel_d = wel;
    if (commit)       wel_d = 1'b0;
    else if (wen_clr) wel_d = 1'b0;
    else if (wen_set) wel_d = 1'b1;

    flag_d = flag;
    if (wen_clr)       flag_d = 1'b0;
    else if (flag_set) flag_d = 1'b1;

    pend_sr_d = pend_sr;
    if (grant_sr)       pend_sr_d = 1'b1;
    else if (grant_arr) pend_sr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wel     <= 1'b0;
      flag    <= 1'b0;
      pend_sr <= 1'b0;
    end else begin
      busy    <= busy_d;
      wel     <= wel_d;
      flag    <= flag_d;
      pend_sr <= pend_sr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= '0;
    else if (pend_en) pend <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     nv <= NV_INIT;
    else if (nv_en) nv <= nv_d;
  end
endmodule

// File: rtl/sr_guard.sv
`timescale 1ns/1ps
module sr_guard
  import srg_pkg::*;
#(
  parameter int  ADDR_W  = 11,
  parameter nv_t NV_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_wr_en_set,
  input  logic              op_wr_en_clr,
  input  logic              op_flag_set,
  input  logic              op_sr_write,
  input  logic              op_arr_write,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        sr_wdata,
  input  logic              lock_pin_n,
  input  logic              wr_done,
  output logic [7:0]        status_q,
  output logic [1:0]        wd_sel,
  output logic              array_grant,
  output logic              status_grant
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       wel, flag, busy, range_hit;
  nv_t        nv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  srg_range_chk #(.ADDR_W(ADDR_W)) i_range (
    .blk  (nv.blk),
    .addr (wr_addr),
    .hit  (range_hit)
  );

  srg_grant i_grant (
    .req_arr    (op_arr_write),
    .req_sr     (op_sr_write),
    .wel        (wel),
    .busy       (busy),
    .lock_en    (nv.lock_en),
    .lock_pin_n (lock_pin_n),
    .range_hit  (range_hit),
    .grant_arr  (array_grant),
    .grant_sr   (status_grant)
  );

  srg_regs #(.NV_INIT(NV_INIT)) i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wen_set   (op_wr_en_set),
    .wen_clr   (op_wr_en_clr),
    .flag_set  (op_flag_set),
    .grant_arr (array_grant),
    .grant_sr  (status_grant),
    .sr_wdata  (sr_wdata),
    .wr_done   (wr_done),
    .wel       (wel),
    .flag      (flag),
    .busy      (busy),
    .nv        (nv)
  );

  assign status_q = pack_status(nv, flag, wel, busy);
  assign wd_sel   = nv.wdsel;
endmodule

// File: rtl/srg_chk.sv
`timescale 1ns/1ps
module srg_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       op_wr_en_set,
  input logic       op_wr_en_clr,
  input logic       op_flag_set,
  input logic       lock_pin_n,
  input logic       wr_done,
  input logic [7:0] status_q,
  input logic       array_grant,
  input logic       status_grant
);
  p_arr_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    array_grant |-> status_q[1]);

  p_all_locked_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (status_q[3:2] == 2'b11) |-> !array_grant);

  p_clr_wel_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    op_wr_en_clr |=> !status_q[1]);

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_flag_set && !op_wr_en_clr) |=> status_q[6]);

  p_sr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (status_q[7] && !lock_pin_n) |-> !status_grant);

  p_busy_refuse_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    status_q[0] |-> (!array_grant && !status_grant));

  p_grant_busy_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (array_grant || status_grant) |=> status_q[0]);

  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (status_q[0] && wr_done) |=> (!status_q[0] && !status_q[1]));

  p_nv_hold_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    !(status_q[0] && wr_done) |=> $stable({status_q[7], status_q[3:2]}));

  p_idle_done_r11: assert property (@(posedge clk) disable iff (!rst_ok)
    (!status_q[0] && wr_done && !op_wr_en_set && !op_wr_en_clr) |=> $stable(status_q[1]));
endmodule

bind sr_guard srg_chk i_srg_chk (
  .clk          (clk),
  .rst_ok       (rst_sync_n),
  .op_wr_en_set (op_wr_en_set),
  .op_wr_en_clr (op_wr_en_clr),
  .op_flag_set  (op_flag_set),
  .lock_pin_n   (lock_pin_n),
  .wr_done      (wr_done),
  .status_q     (status_q),
  .array_grant  (array_grant),
  .status_grant (status_grant)
);

// File: tb/test_sr_guard.sv
`timescale 1ns/1ps
module test_sr_guard;
  localparam int AW = 11;
  localparam int OP_NOP = 0, OP_SET = 1, OP_CLR = 2, OP_FLG = 3,
                 OP_SRW = 4, OP_ARW = 5, OP_DONE = 6;
  localparam int WD_CYCLES = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_wr_en_set = 0, op_wr_en_clr = 0, op_flag_set = 0;
  logic          op_sr_write = 0, op_arr_write = 0, wr_done = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    sr_wdata = '0;
  logic          lock_pin_n = 1'b1;
  logic [7:0]    status_q;
  logic [1:0]    wd_sel;
  logic          array_grant, status_grant;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sr_guard #(.ADDR_W(AW)) i_sr_guard (
    .clk(clk), .rst_n(rst_n),
    .op_wr_en_set(op_wr_en_set), .op_wr_en_clr(op_wr_en_clr),
    .op_flag_set(op_flag_set), .op_sr_write(op_sr_write),
    .op_arr_write(op_arr_write), .wr_addr(wr_addr), .sr_wdata(sr_wdata),
    .lock_pin_n(lock_pin_n), .wr_done(wr_done),
    .status_q(status_q), .wd_sel(wd_sel),
    .array_grant(array_grant), .status_grant(status_grant)
  );

  // {req[3:0], op[2:0], pin, addr[10:0], data[7:0], grant, status[7:0], wd[1:0]}
  function automatic logic [37:0] mk(input int req, input int op, input bit pin,
                                     input logic [10:0] a, input logic [7:0] d,
                                     input bit g, input logic [7:0] s,
                                     input logic [1:0] w);
    return {req[3:0], op[2:0], pin, a, d, g, s, w};
  endfunction

  localparam logic [37:0] TBL [0:19] = '{
    mk(3, OP_ARW, 1, 11'h100, 8'h00, 0, 8'h00, 2'd0),  // R3 no latch
    mk(5, OP_SET, 1, 11'h000, 8'h00, 0, 8'h02, 2'd0),  // R5
    mk(6, OP_FLG, 1, 11'h000, 8'h00, 0, 8'h42, 2'd0),  // R6
    mk(3, OP_ARW, 1, 11'h100, 8'h00, 1, 8'h43, 2'd0),  // R3 granted
    mk(8, OP_ARW, 1, 11'h200, 8'h00, 0, 8'h43, 2'd0),  // R8 busy refuse
    mk(8, OP_DONE,1, 11'h000, 8'h00, 0, 8'h40, 2'd0),  // R8 done
    mk(6, OP_CLR, 1, 11'h000, 8'h00, 0, 8'h00, 2'd0),  // R6 clear
    mk(5, OP_SET, 1, 11'h000, 8'h00, 0, 8'h02, 2'd0),  // R5
    mk(9, OP_SRW, 1, 11'h000, 8'hF7, 1, 8'h03, 2'd0),  // R9 pending
    mk(9, OP_DONE,1, 11'h000, 8'h00, 0, 8'h84, 2'd3),  // R9 commit
    mk(5, OP_SET, 1, 11'h000, 8'h00, 0, 8'h86, 2'd3),  // R5
    mk(4, OP_ARW, 1, 11'h600, 8'h00, 0, 8'h86, 2'd3),  // R4 quarter edge
    mk(4, OP_ARW, 1, 11'h5FF, 8'h00, 1, 8'h87, 2'd3),  // R4 below quarter
    mk(8, OP_DONE,1, 11'h000, 8'h00, 0, 8'h84, 2'd3),  // R8
    mk(5, OP_SET, 0, 11'h000, 8'h00, 0, 8'h86, 2'd3),  // R5
    mk(7, OP_SRW, 0, 11'h000, 8'h00, 0, 8'h86, 2'd3),  // R7 frozen
    mk(7, OP_SRW, 1, 11'h000, 8'h08, 1, 8'h87, 2'd3),  // R7 pin high
    mk(9, OP_DONE,1, 11'h000, 8'h00, 0, 8'h08, 2'd0),  // R9
    mk(5, OP_CLR, 1, 11'h000, 8'h00, 0, 8'h08, 2'd0),  // R5
    mk(3, OP_ARW, 1, 11'h7FF, 8'h00, 0, 8'h08, 2'd0)   // R3
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int req, input int op, input bit pin,
                      input logic [10:0] a, input logic [7:0] d, input bit g,
                      input logic [7:0] es, input logic [1:0] ew);
    lock_pin_n   = pin;
    wr_addr      = a;
    sr_wdata     = d;
    op_wr_en_set = (op == OP_SET);
    op_wr_en_clr = (op == OP_CLR);
    op_flag_set  = (op == OP_FLG);
    op_sr_write  = (op == OP_SRW);
    op_arr_write = (op == OP_ARW);
    wr_done      = (op == OP_DONE);
    #5;
    chk(array_grant  == ((op == OP_ARW) && g), req, "array_grant",  array_grant,  (op == OP_ARW) && g);
    chk(status_grant == ((op == OP_SRW) && g), req, "status_grant", status_grant, (op == OP_SRW) && g);
    @(negedge clk);
    chk(status_q == es, req, "status_q", status_q, es);
    chk(wd_sel == ew, req, "wd_sel", wd_sel, ew);
    {op_wr_en_set, op_wr_en_clr, op_flag_set, op_sr_write, op_arr_write, wr_done} = '0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(WD_CYCLES * 20);
    if (!finished) begin
      n_fail++;
      $display("FAIL R0 watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #2;
    chk(status_q == 8'h00, 1, "status_q in reset", status_q, 8'h00);  // R1
    chk(!array_grant && !status_grant, 1, "grants in reset", {array_grant, status_grant}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(status_q == 8'h00, 1, "status_q after reset", status_q, 8'h00);  // R1
    chk(wd_sel == 2'd0, 1, "wd_sel after reset", wd_sel, 0);

    for (int i = 0; i < 20; i++) begin
      logic [37:0] v;
      v = TBL[i];
      step(int'(v[37:34]), int'(v[33:31]), v[30], v[29:19], v[18:11], v[10], v[9:2], v[1:0]);
    end

    // R10: pin drops while a status write is in flight
    step(10, OP_SET, 1, 0, 8'h00, 0, 8'h0A, 0);
    step(10, OP_SRW, 1, 0, 8'h80, 1, 8'h0B, 0);
    step(10, OP_NOP, 0, 0, 8'h00, 0, 8'h0B, 0);
    step(10, OP_DONE,0, 0, 8'h00, 0, 8'h80, 0);
    step(10, OP_SET, 0, 0, 8'h00, 0, 8'h82, 0);
    step(10, OP_SRW, 0, 0, 8'h00, 0, 8'h82, 0);
    // R4: full protection, code 11
    step(7,  OP_SRW, 1, 0, 8'h0C, 1, 8'h83, 0);
    step(9,  OP_DONE,1, 0, 8'h00, 0, 8'h0C, 0);
    step(5,  OP_SET, 1, 0, 8'h00, 0, 8'h0E, 0);
    step(4,  OP_ARW, 1, 11'h000, 8'h00, 0, 8'h0E, 0);
    step(4,  OP_ARW, 1, 11'h7FF, 8'h00, 0, 8'h0E, 0);
    // R11: done while idle
    step(11, OP_DONE,1, 0, 8'h00, 0, 8'h0E, 0);
    // R4: half protection, code 10, both sides of 0x400
    step(7,  OP_SRW, 1, 0, 8'h08, 1, 8'h0F, 0);
    step(9,  OP_DONE,1, 0, 8'h00, 0, 8'h08, 0);
    step(5,  OP_SET, 1, 0, 8'h00, 0, 8'h0A, 0);
    step(4,  OP_ARW, 1, 11'h400, 8'h00, 0, 8'h0A, 0);
    step(4,  OP_ARW, 1, 11'h3FF, 8'h00, 1, 8'h0B, 0);
    step(8,  OP_DONE,1, 0, 8'h00, 0, 8'h08, 0);
    // R2: flag lands in bit 6 alongside protect code in bits 3:2
    step(2,  OP_FLG, 1, 0, 8'h00, 0, 8'h48, 0);

    // R1: reset in mid-operation
    rst_n = 1'b0;
    #2;
    chk(status_q == 8'h00, 1, "status_q async reset", status_q, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(status_q == 8'h00, 1, "status_q re-reset", status_q, 8'h00);
    chk(wd_sel == 2'd0, 1, "wd_sel re-reset", wd_sel, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule